// File: doc/BRIEF.md
# Slow-Clock Reset Sequencer with Reset-Type Record

This block sequences the processor and peripheral resets of a chip from a slow always-on clock. An active-low reset pin is brought into the slow-clock domain through a short synchronizer. When user resets are enabled, a low level on that pin starts a user reset. Both internal resets fall, the processor clock is gated off, and the block itself drives the pin low for a programmable minimum time. When the pin is seen high again, the block restarts the processor clock, waits a fixed startup time, and releases both resets together. At that moment it records which kind of reset just ended.

A request from the supply side on return from backup mode takes a shorter path. The resets are asserted and the clock stays running through the same startup wait. On release the record shows a backup reset. The record is a 3-bit code: 0 after power-up, 1 after a backup reset, 4 after a user reset. It changes only at the cycle in which the processor reset is released.

The controller has three states. `ST_RUN` has all resets released and the clock enabled. `ST_USER` has the resets held, the clock gated and the pin stretched. `ST_START` has the resets held and the clock enabled while the startup count runs. The transitions are as follows:
- `ST_RUN` goes to `ST_USER` on an enabled, synchronized pin low.
- `ST_RUN` goes to `ST_START` on a backup request.
- `ST_USER` goes to `ST_START` once the stretch has expired and the pin reads high.
- `ST_START` goes back to `ST_USER` on an enabled pin low, which restarts the sequence.
- `ST_START` goes to `ST_RUN` when the startup count ends, which also latches the record.

Top module: `slow_reset_sequencer`

## Requirements
- R1: With `user_rst_en`=1, a falling edge of `pin_in` pulls `proc_rst_n` and `periph_rst_n` low, pulls `cpu_clk_en` low and sets `pin_drive_low` high, all on the third rising clock edge after the fall.
- R2: With `user_rst_en`=0, a low `pin_in` leaves `proc_rst_n` high, `pin_drive_low` low and `rst_kind` unchanged.
- R3: After a user reset is entered, `pin_drive_low` stays high for exactly 2^(`stretch_len`+1) clock cycles.
- R4: While `pin_in` is held low from outside after the stretch has ended, `proc_rst_n`, `periph_rst_n` and `cpu_clk_en` all stay low.
- R5: `cpu_clk_en` rises on the third rising edge after `pin_in` rises at the end of a user reset.
- R6: `proc_rst_n` and `periph_rst_n` rise together on the third rising edge after `cpu_clk_en` rises.
- R7: `rst_kind` takes the value 4 on the cycle in which `proc_rst_n` rises after a user reset, and it keeps its previous value before that cycle.
- R8: A one-cycle `backup_req` while the block is running pulls both resets low on the next edge with `cpu_clk_en` left high. The resets stay low for 3 cycles and `rst_kind` becomes 1 at their release.
- R9: With `user_rst_en`=1, a synchronized pin low during the startup wait returns the block to the user reset state. `pin_drive_low` rises, `cpu_clk_en` falls, and the sequence ends with `rst_kind`=4.
- R10: While `rst_n` is low, the outputs are `proc_rst_n`=1, `periph_rst_n`=1, `cpu_clk_en`=1, `pin_drive_low`=0 and `rst_kind`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset of the sequencer |
| pin_in | input | 1 | Raw level of the active-low reset pin |
| user_rst_en | input | 1 | 1 lets a low pin start a user reset |
| backup_req | input | 1 | Backup-exit reset request, one cycle |
| stretch_len | input | 4 | Pin stretch exponent; the stretch is 2^(value+1) cycles |
| proc_rst_n | output | 1 | Active-low processor reset |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| pin_drive_low | output | 1 | 1 pulls the reset pin low (open-drain enable) |
| cpu_clk_en | output | 1 | Processor clock enable |
| rst_kind | output | 3 | Code of the last completed reset |

## Verification
The bench builds the block with its default parameters: a 4-bit stretch field, two synchronizer stages and a three-cycle startup. With these defaults, the stretch values 0, 1, 2, 3, 7 and 15 can all be reached in one run, from the shortest stretch of 2 cycles to the longest of 65536 cycles. The pin is modelled as a wired line that either the block or the bench can pull low. This lets the bench hold the line low past the stretch, and pull it low during a backup startup so that a restart is forced.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_USER  = 2'd1,
        ST_START = 2'd2
    } seq_state_t;

    localparam int KIND_W = 3;
    localparam logic [KIND_W-1:0] KIND_POWERUP = 3'd0;
    localparam logic [KIND_W-1:0] KIND_BACKUP  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_USER    = 3'd4;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_stretch_timer.sv
module rst_stretch_timer #(
    parameter int LEN_W = 4,
    localparam int CNT_W = (1 << LEN_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             run,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;
    logic [LEN_W:0]   shift;

    assign shift = {1'b0, len} + {{LEN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= {{(CNT_W-1){1'b0}}, 1'b1} << shift;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/slow_reset_sequencer.sv
module slow_reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STARTUP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              user_rst_en,
    input  logic              backup_req,
    input  logic [LEN_W-1:0]  stretch_len,
    output logic              proc_rst_n,
    output logic              periph_rst_n,
    output logic              pin_drive_low,
    output logic              cpu_clk_en,
    output logic [KIND_W-1:0] rst_kind
);
    localparam int SU_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
    localparam logic [SU_W-1:0] SU_LOAD = SU_W'(STARTUP_CYC - 1);

    seq_state_t        state, state_nx;
    logic              pin_sync;
    logic              stretch_busy;
    logic              stretch_load;
    logic              user_low;
    logic [SU_W-1:0]   su_cnt;
    logic [KIND_W-1:0] kind_pend;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pin_in),
        .d_sync (pin_sync)
    );

    rst_stretch_timer #(.LEN_W(LEN_W)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stretch_load),
        .len   (stretch_len),
        .run   (state == ST_USER),
        .busy  (stretch_busy)
    );

    assign user_low = user_rst_en && !pin_sync;

    always_comb begin
        state_nx     = state;
        stretch_load = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (user_low) begin
                    state_nx     = ST_USER;
                    stretch_load = 1'b1;
                end else if (backup_req) begin
                    state_nx = ST_START;
                end
            end
            ST_USER: begin
                if (!stretch_busy && pin_sync)
                    state_nx = ST_START;
            end
            ST_START: begin
                if (user_low) begin
                    state_nx     = ST_USER;
                    stretch_load = 1'b1;
                end else if (su_cnt == '0) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_cnt    <= '0;
            kind_pend <= KIND_POWERUP;
            rst_kind  <= KIND_POWERUP;
        end else begin
            if (state != ST_START && state_nx == ST_START)
                su_cnt <= SU_LOAD;
            else if (state == ST_START && su_cnt != '0)
                su_cnt <= su_cnt - 1'b1;

            if (state == ST_RUN && state_nx == ST_START)
                kind_pend <= KIND_BACKUP;
            else if (state_nx == ST_USER)
                kind_pend <= KIND_USER;

            if (state == ST_START && state_nx == ST_RUN)
                rst_kind <= kind_pend;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN: begin
                proc_rst_n    = 1'b1;
                periph_rst_n  = 1'b1;
                cpu_clk_en    = 1'b1;
                pin_drive_low = 1'b0;
            end
            ST_USER: begin
                proc_rst_n    = 1'b0;
                periph_rst_n  = 1'b0;
                cpu_clk_en    = 1'b0;
                pin_drive_low = stretch_busy;
            end
            ST_START: begin
                proc_rst_n    = 1'b0;
                periph_rst_n  = 1'b0;
                cpu_clk_en    = 1'b1;
                pin_drive_low = 1'b0;
            end
            default: begin
                proc_rst_n    = 1'b1;
                periph_rst_n  = 1'b1;
                cpu_clk_en    = 1'b1;
                pin_drive_low = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slow_reset_sequencer_chk.sv
module slow_reset_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_sync,
    input logic       user_rst_en,
    input logic       backup_req,
    input logic       proc_rst_n,
    input logic       periph_rst_n,
    input logic       pin_drive_low,
    input logic       cpu_clk_en,
    input logic [2:0] rst_kind
);
    AST_ENTRY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rst_n && user_rst_en && !pin_sync) |=> !proc_rst_n); // R1
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rst_n && !user_rst_en && !backup_req) |=> proc_rst_n); // R2
    AST_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_low |-> (!proc_rst_n && !cpu_clk_en)); // R3
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_rst_n && !cpu_clk_en && !pin_sync) |=> (!proc_rst_n && !cpu_clk_en)); // R4
    AST_CLK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_rst_n) |-> $past(cpu_clk_en)); // R6
    AST_PERIPH_WITH_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_rst_n) |-> $rose(periph_rst_n)); // R6
    AST_KIND_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_kind) |-> $rose(proc_rst_n)); // R7
    AST_BACKUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rst_n && backup_req && !(user_rst_en && !pin_sync)) |=> (!proc_rst_n && cpu_clk_en)); // R8
endmodule

bind slow_reset_sequencer slow_reset_sequencer_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_sync      (pin_sync),
    .user_rst_en   (user_rst_en),
    .backup_req    (backup_req),
    .proc_rst_n    (proc_rst_n),
    .periph_rst_n  (periph_rst_n),
    .pin_drive_low (pin_drive_low),
    .cpu_clk_en    (cpu_clk_en),
    .rst_kind      (rst_kind)
);

// File: tb/slow_reset_sequencer_tb.sv
module slow_reset_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_low = 1'b0;
    logic       user_rst_en = 1'b0;
    logic       backup_req = 1'b0;
    logic [3:0] stretch_len = 4'd0;
    logic       proc_rst_n, periph_rst_n, pin_drive_low, cpu_clk_en;
    logic [2:0] rst_kind;
    logic       pin_in;

    int n_checks = 0;
    int n_fails  = 0;

    assign pin_in = ~(pin_drive_low | ext_low);

    always #5 clk = ~clk;

    slow_reset_sequencer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .user_rst_en   (user_rst_en),
        .backup_req    (backup_req),
        .stretch_len   (stretch_len),
        .proc_rst_n    (proc_rst_n),
        .periph_rst_n  (periph_rst_n),
        .pin_drive_low (pin_drive_low),
        .cpu_clk_en    (cpu_clk_en),
        .rst_kind      (rst_kind)
    );

    localparam int NVEC = 6;
    localparam int unsigned VEC [NVEC][2] = '{
        '{0, 2}, '{1, 4}, '{2, 8}, '{3, 16}, '{7, 256}, '{15, 65536}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // From a negedge where the pin has just been released, measure clock
    // re-enable and reset release, and check the reset-type record.
    task automatic exit_phase(input int old_kind, input int exp_kind, input string tag);
        int c = 0;
        while (!cpu_clk_en && c < 20) begin @(negedge clk); c++; end
        check(c == 3, "R5 clk_en delay", c, 3);
        check(rst_kind == old_kind, "R7 kind before release", rst_kind, old_kind);
        check(!proc_rst_n, "R6 still in reset at clk_en", proc_rst_n, 0);
        c = 0;
        while (!proc_rst_n && c < 20) begin @(negedge clk); c++; end
        check(c == 3, "R6 release delay", c, 3);
        check(periph_rst_n == 1'b1, "R6 periph released with proc", periph_rst_n, 1);
        check(rst_kind == exp_kind, tag, rst_kind, exp_kind);
    endtask

    task automatic user_cycle(input int len, input int exp_len);
        int c = 0;
        int n = 0;
        int old_kind;
        old_kind = rst_kind;
        stretch_len = len[3:0];
        user_rst_en = 1'b1;
        ext_low = 1'b1;
        while (proc_rst_n && c < 20) begin @(negedge clk); c++; end
        check(c == 3, "R1 entry delay", c, 3);
        check(!periph_rst_n && !cpu_clk_en && pin_drive_low, "R1 entry outputs",
              {periph_rst_n, cpu_clk_en, pin_drive_low}, 3'b001);
        ext_low = 1'b0;
        while (pin_drive_low && n < 70000) begin n++; @(negedge clk); end
        check(n == exp_len, "R3 stretch length", n, exp_len);
        exit_phase(old_kind, 4, "R7 user kind");
    endtask

    initial begin
        int c;
        int bad;
        #1;
        check(proc_rst_n && periph_rst_n && cpu_clk_en && !pin_drive_low && rst_kind == 0,
              "R10 reset state",
              {proc_rst_n, periph_rst_n, cpu_clk_en, pin_drive_low, rst_kind}, 7'b1110000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: pin low with user resets disabled
        user_rst_en = 1'b0;
        ext_low = 1'b1;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (!proc_rst_n || pin_drive_low) bad++;
        end
        check(bad == 0, "R2 disabled pin low ignored", bad, 0);
        check(rst_kind == 0, "R2 kind unchanged", rst_kind, 0);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);

        // R8: backup reset
        backup_req = 1'b1;
        @(negedge clk);
        backup_req = 1'b0;
        check(!proc_rst_n && !periph_rst_n && cpu_clk_en, "R8 backup entry",
              {proc_rst_n, periph_rst_n, cpu_clk_en}, 3'b001);
        c = 1;
        while (!proc_rst_n && c < 20) begin @(negedge clk); c++; end
        check(c == 4, "R8 backup release", c, 4);
        check(rst_kind == 1, "R8 backup kind", rst_kind, 1);

        // R4: pin held low externally past the stretch
        stretch_len = 4'd0;
        user_rst_en = 1'b1;
        ext_low = 1'b1;
        c = 0;
        while (proc_rst_n && c < 20) begin @(negedge clk); c++; end
        check(c == 3, "R1 entry delay (hold case)", c, 3);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (proc_rst_n || periph_rst_n || cpu_clk_en) bad++;
        end
        check(bad == 0, "R4 held while pin low", bad, 0);
        check(!pin_drive_low, "R4 stretch over while held", pin_drive_low, 0);
        ext_low = 1'b0;
        exit_phase(1, 4, "R7 user kind after hold");

        // another backup to set the record to 1
        repeat (2) @(negedge clk);
        backup_req = 1'b1;
        @(negedge clk);
        backup_req = 1'b0;
        repeat (4) @(negedge clk);
        check(rst_kind == 1, "R8 second backup kind", rst_kind, 1);

        // R9: pin low during the startup wait restarts the user sequence
        backup_req = 1'b1;
        ext_low = 1'b1;
        @(negedge clk);
        backup_req = 1'b0;
        check(!proc_rst_n && cpu_clk_en, "R8 startup entered", {proc_rst_n, cpu_clk_en}, 2'b01);
        c = 0;
        bad = 0;
        while (!pin_drive_low && c < 20) begin
            @(negedge clk);
            c++;
            if (proc_rst_n) bad++;
        end
        check(c == 2 && bad == 0, "R9 restart into user reset", c, 2);
        check(!cpu_clk_en, "R9 clock gated on restart", cpu_clk_en, 0);
        ext_low = 1'b0;
        while (pin_drive_low && c < 100) begin @(negedge clk); c++; end
        exit_phase(1, 4, "R9 kind after restart");

        // table of stretch lengths
        for (int i = 0; i < NVEC; i++) begin
            repeat (3) @(negedge clk);
            user_cycle(int'(VEC[i][0]), int'(VEC[i][1]));
        end

        finish_summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_summary();
    end
endmodule